// File: doc/BRIEF.md
# Two-level translation table walker

The walker turns a 32-bit virtual address into a physical address by reading descriptors from a two-level translation table held in memory. A client raises a request with the virtual address. The walker then reads the level-1 descriptor through a memory read port that has a valid/ready request channel and a response whose latency can vary. From that descriptor it either forms the result at once or fetches one level-2 descriptor and forms the result from that.

Level 1 can return a 1 MB section, a 16 MB supersection, a fault, or a pointer to a level-2 table. Level 2 can return a 4 KB small page, a 64 KB large page, or a fault. The outputs are the physical address, a fault flag, a write-allowed flag and an execute-never flag. The execute-never bit sits in a different place in a level-2 descriptor depending on whether it is a small page or a large page. Only one walk is in progress at a time. The result stays on the outputs, marked by a one-cycle done pulse, until the next walk completes.

Top module: `ptw_walker`

## Requirements
- R1: The first fetch of a walk reads address {l1_base_i[31:14], va[31:20], 2'b00}. Bits [13:0] of the base have no effect. The base and the virtual address are sampled when the request is accepted.
- R2: A descriptor whose bits [1:0] are 2'b00 ends the walk at either level with fault_o=1, pa_o=0, write_ok_o=0 and xn_o=0.
- R3: A level-1 descriptor with bit 0 set is a table pointer. The second fetch reads {desc[31:10], va[19:12], 2'b00}.
- R4: A level-1 descriptor with bits [1:0]=2'b10 and bit 18 clear is a section, with pa_o = {desc[31:20], va[19:0]}.
- R5: A level-1 descriptor with bits [1:0]=2'b10 and bit 18 set is a supersection, with pa_o = {desc[31:24], va[23:0]}. Descriptor bits [23:20] are ignored.
- R6: For a level-1 section or supersection, write_ok_o = ~desc[15] and xn_o = desc[4].
- R7: A level-2 descriptor with bit 1 set is a small page. It gives pa_o = {desc[31:12], va[11:0]}, write_ok_o = ~desc[9] and xn_o = desc[0].
- R8: A level-2 descriptor with bits [1:0]=2'b01 is a large page. It gives pa_o = {desc[31:16], va[15:0]}, write_ok_o = ~desc[9] and xn_o = desc[15]; bit 0 does not set xn_o. A walk never fetches more than two descriptors.
- R9: req_ready_o is high only while idle, and a request made while busy is ignored. A memory request stays valid with a stable address until mem_req_ready_i is seen high.
- R10: done_o pulses for one cycle, in the cycle after the response that ends the walk. pa_o, fault_o, write_ok_o and xn_o hold their values until the next done_o.
- R11: A memory response that arrives while no fetch is outstanding (idle, or a request not yet accepted by memory) is ignored.
- R12: While rst_ni is low, the walker is idle with done_o, mem_req_valid_o and all result outputs at 0. A fetch in flight is dropped, and its late response is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_va_i | input | 32 | Virtual address to translate |
| l1_base_i | input | 32 | Level-1 table base, 16 KB aligned |
| mem_req_valid_o | output | 1 | Descriptor fetch request |
| mem_req_ready_i | input | 1 | Memory accepts the fetch |
| mem_req_addr_o | output | 32 | Descriptor byte address |
| mem_rsp_valid_i | input | 1 | Descriptor data valid |
| mem_rsp_data_i | input | 32 | Descriptor word |
| done_o | output | 1 | One-cycle pulse, walk complete |
| pa_o | output | 32 | Physical address result |
| fault_o | output | 1 | Translation fault |
| write_ok_o | output | 1 | Writes permitted |
| xn_o | output | 1 | Execute-never |

## Verification
The assertions check the following rules on every cycle:
- The request handshake and the busy/ready exclusion.
- A stable fetch address under back-pressure.
- The level-1 fetch address built from the sampled base and index.
- The cap of two fetches per walk.
- A single-cycle done that always follows a response.
- Zeroed results on a fault.
- Results held between completions.

Only the bench scenarios can show that each descriptor type produces the right address join and the right permission and execute-never bits. The same holds for the difference between execute-never in small and large pages, for responses that arrive when nothing is outstanding being ignored, and for a fetch dropped by reset.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W        = 32;
  localparam int L1_IDX_W    = 12;
  localparam int L2_IDX_W    = 8;
  localparam int OFF_W       = 12;
  localparam int L1_ALIGN    = L1_IDX_W + 2;
  localparam int L2_ALIGN    = L2_IDX_W + 2;
  localparam int SECT_OFF_W  = VA_W - L1_IDX_W;
  localparam int SUPER_OFF_W = 24;
  localparam int LARGE_OFF_W = 16;
  localparam int SUPER_BIT   = 18;
  localparam int L1_RO_BIT   = 15;
  localparam int L1_XN_BIT   = 4;
  localparam int L2_RO_BIT   = 9;
  localparam int SMALL_XN_BIT = 0;
  localparam int LARGE_XN_BIT = 15;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT
  } walk_state_e;

  typedef enum logic [2:0] {
    K_FAULT, K_TABLE, K_SECTION, K_SUPER, K_SMALL, K_LARGE
  } desc_kind_e;

  typedef struct packed {
    logic [VA_W-1:0] pa;
    logic            fault;
    logic            write_ok;
    logic            xn;
  } walk_res_t;

  function automatic logic [VA_W-1:0] join_addr(logic [VA_W-1:0] d,
                                                logic [VA_W-1:0] va,
                                                int unsigned     low_w);
    logic [VA_W-1:0] hi;
    hi = {VA_W{1'b1}} << low_w;
    return (d & hi) | (va & ~hi);
  endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int AW = VA_W
) (
  input  logic          lvl2_i,
  input  logic [AW-1:0] va_i,
  input  logic [AW-1:0] l1_base_i,
  input  logic [AW-1:0] l2_base_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] L1_MASK = {AW{1'b1}} << L1_ALIGN;
  localparam logic [AW-1:0] L2_MASK = {AW{1'b1}} << L2_ALIGN;
  localparam logic [AW-1:0] L1_IDX_M = (AW'(1) << L1_IDX_W) - AW'(1);
  localparam logic [AW-1:0] L2_IDX_M = (AW'(1) << L2_IDX_W) - AW'(1);

  logic [AW-1:0] l1_idx, l2_idx;

  always_comb begin
    l1_idx = (va_i >> (AW - L1_IDX_W)) & L1_IDX_M;
    l2_idx = (va_i >> OFF_W) & L2_IDX_M;
    if (lvl2_i) addr_o = (l2_base_i & L2_MASK) | (l2_idx << 2);
    else        addr_o = (l1_base_i & L1_MASK) | (l1_idx << 2);
  end
endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
  import ptw_pkg::*;
#(
  parameter int AW = VA_W
) (
  input  logic          lvl2_i,
  input  logic [AW-1:0] desc_i,
  input  logic [AW-1:0] va_i,
  output desc_kind_e    kind_o,
  output walk_res_t     res_o,
  output logic [AW-1:0] next_base_o
);
  localparam logic [AW-1:0] TBL_MASK = {AW{1'b1}} << L2_ALIGN;

  logic valid;

  always_comb begin
    valid = desc_i[1:0] != 2'b00;
    if (!valid)             kind_o = K_FAULT;
    else if (lvl2_i)        kind_o = desc_i[1] ? K_SMALL : K_LARGE;
    else if (desc_i[0])     kind_o = K_TABLE;
    else if (desc_i[SUPER_BIT]) kind_o = K_SUPER;
    else                    kind_o = K_SECTION;
  end

  always_comb begin
    res_o = '0;
    unique case (kind_o)
      K_FAULT:   res_o.fault = 1'b1;
      K_SECTION: begin
        res_o.pa       = join_addr(desc_i, va_i, SECT_OFF_W);
        res_o.write_ok = ~desc_i[L1_RO_BIT];
        res_o.xn       = desc_i[L1_XN_BIT];
      end
      K_SUPER: begin
        res_o.pa       = join_addr(desc_i, va_i, SUPER_OFF_W);
        res_o.write_ok = ~desc_i[L1_RO_BIT];
        res_o.xn       = desc_i[L1_XN_BIT];
      end
      K_SMALL: begin
        res_o.pa       = join_addr(desc_i, va_i, OFF_W);
        res_o.write_ok = ~desc_i[L2_RO_BIT];
        res_o.xn       = desc_i[SMALL_XN_BIT];
      end
      K_LARGE: begin
        res_o.pa       = join_addr(desc_i, va_i, LARGE_OFF_W);
        res_o.write_ok = ~desc_i[L2_RO_BIT];
        res_o.xn       = desc_i[LARGE_XN_BIT];
      end
      default: res_o = '0;
    endcase
  end

  assign next_base_o = desc_i & TBL_MASK;
endmodule

// File: rtl/ptw_result_reg.sv
module ptw_result_reg
  import ptw_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  walk_res_t res_i,
  output walk_res_t res_o,
  output logic      done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= load_i;
      if (load_i) res_o <= res_i;
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int AW = VA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_va_i,
  input  logic [AW-1:0] l1_base_i,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic [AW-1:0] mem_req_addr_o,
  input  logic          mem_rsp_valid_i,
  input  logic [AW-1:0] mem_rsp_data_i,
  output logic          done_o,
  output logic [AW-1:0] pa_o,
  output logic          fault_o,
  output logic          write_ok_o,
  output logic          xn_o
);
  walk_state_e   state_q, state_d;
  logic [AW-1:0] va_q, base_q, l2_base_q;
  logic          lvl2, rsp_take, finish, accept;
  desc_kind_e    kind;
  walk_res_t     dec_res, res_q;
  logic [AW-1:0] next_base;

  assign lvl2        = (state_q == ST_L2_REQ) || (state_q == ST_L2_WAIT);
  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign mem_req_valid_o = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  // responses only count while a fetch is outstanding
  assign rsp_take = mem_rsp_valid_i &&
                    ((state_q == ST_L1_WAIT) || (state_q == ST_L2_WAIT));
  assign finish   = rsp_take && (kind != K_TABLE);

  ptw_addr_gen #(.AW(AW)) i_addr_gen (
    .lvl2_i    (lvl2),
    .va_i      (va_q),
    .l1_base_i (base_q),
    .l2_base_i (l2_base_q),
    .addr_o    (mem_req_addr_o)
  );

  ptw_desc_decode #(.AW(AW)) i_decode (
    .lvl2_i      (lvl2),
    .desc_i      (mem_rsp_data_i),
    .va_i        (va_q),
    .kind_o      (kind),
    .res_o       (dec_res),
    .next_base_o (next_base)
  );

  ptw_result_reg i_result (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (finish),
    .res_i  (dec_res),
    .res_o  (res_q),
    .done_o (done_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = ST_L1_REQ;
      ST_L1_REQ:  if (mem_req_ready_i) state_d = ST_L1_WAIT;
      ST_L1_WAIT: if (rsp_take) state_d = finish ? ST_IDLE : ST_L2_REQ;
      ST_L2_REQ:  if (mem_req_ready_i) state_d = ST_L2_WAIT;
      ST_L2_WAIT: if (rsp_take) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      va_q      <= '0;
      base_q    <= '0;
      l2_base_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        va_q   <= req_va_i;
        base_q <= l1_base_i;
      end
      if (rsp_take && kind == K_TABLE) l2_base_q <= next_base;
    end
  end

  assign pa_o       = res_q.pa;
  assign fault_o    = res_q.fault;
  assign write_ok_o = res_q.write_ok;
  assign xn_o       = res_q.xn;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [AW-1:0] req_va_i,
  input logic [AW-1:0] l1_base_i,
  input logic          mem_req_valid_o,
  input logic          mem_req_ready_i,
  input logic [AW-1:0] mem_req_addr_o,
  input logic          mem_rsp_valid_i,
  input logic          done_o,
  input logic [AW-1:0] pa_o,
  input logic          fault_o,
  input logic          write_ok_o,
  input logic          xn_o
);
  logic [2:0]    fetch_cnt_q;
  logic [AW-1:0] va_c, base_c, l1_exp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_cnt_q <= '0;
      va_c        <= '0;
      base_c      <= '0;
    end else if (req_valid_i && req_ready_o) begin
      fetch_cnt_q <= '0;
      va_c        <= req_va_i;
      base_c      <= l1_base_i;
    end else if (mem_req_valid_o && mem_req_ready_i && fetch_cnt_q != 3'd7) begin
      fetch_cnt_q <= fetch_cnt_q + 3'd1;
    end
  end

  assign l1_exp = {base_c[AW-1:14], va_c[AW-1:20], 2'b00};

  assert_l1_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && fetch_cnt_q == 3'd0) |-> mem_req_addr_o == l1_exp);

  assert_fault_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (pa_o == '0 && !write_ok_o && !xn_o));

  assert_max_two_fetch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_cnt_q <= 3'd2);

  assert_busy_not_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_rsp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_rsp_valid_i));

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(pa_o) && $stable(fault_o) && $stable(write_ok_o) && $stable(xn_o)));
endmodule

bind ptw_walker ptw_walker_chk #(.AW(AW)) i_ptw_walker_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .req_va_i        (req_va_i),
  .l1_base_i       (l1_base_i),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .done_o          (done_o),
  .pa_o            (pa_o),
  .fault_o         (fault_o),
  .write_ok_o      (write_ok_o),
  .xn_o            (xn_o)
);

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [31:0] l1_base = 32'h0010_0000;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done;
  logic [31:0] pa;
  logic        fault, write_ok, xn;

  always #2 clk = ~clk;

  ptw_walker i_ptw_walker (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .l1_base_i(l1_base),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
    .done_o(done), .pa_o(pa), .fault_o(fault), .write_ok_o(write_ok), .xn_o(xn)
  );

  int n_checks = 0;
  int n_fail = 0;

  logic [31:0] mem_q [logic [31:0]];
  int          lat = 0;
  int          ready_mode = 0;
  int          fetch_cnt = 0;
  int          done_cnt = 0;
  bit          stray_pend = 1'b0;
  logic [31:0] stray_data = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // memory model: driven at the falling edge
  initial begin
    bit          pend = 1'b0;
    int          cnt = 0;
    logic [31:0] paddr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (done) done_cnt++;
      if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_q.exists(paddr) ? mem_q[paddr] : 32'h0;
          pend = 1'b0;
        end else cnt--;
      end else if (stray_pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = stray_data;
        stray_pend    = 1'b0;
      end
      case (ready_mode)
        0:       mem_req_ready = 1'b1;
        1:       mem_req_ready = ~mem_req_ready;
        default: mem_req_ready = 1'b0;
      endcase
      if (mem_req_valid && mem_req_ready && rst_ni) begin
        pend = 1'b1; cnt = lat; paddr = mem_req_addr; fetch_cnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    report();
    $finish;
  end

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] l1;
    logic [31:0] l2;
    logic [31:0] pa;
    logic        fault;
    logic        wr;
    logic        xn;
    logic [1:0]  nfetch;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h1234_5678, 32'h8760_0002, 32'h0, 32'h8764_5678, 1'b0, 1'b1, 1'b0, 2'd1}, // R4 section
    '{32'h1234_5678, 32'h4560_8012, 32'h0, 32'h4564_5678, 1'b0, 1'b0, 1'b1, 2'd1}, // R6 RO+XN
    '{32'h0ABC_DEF0, 32'hF5F4_0002, 32'h0, 32'hF5BC_DEF0, 1'b0, 1'b1, 1'b0, 2'd1}, // R5 super
    '{32'h1234_5678, 32'hFFFF_FFFC, 32'h0, 32'h0,         1'b1, 1'b0, 1'b0, 2'd1}, // R2 L1
    '{32'h0030_1ABC, 32'h0020_0401, 32'h7777_7002, 32'h7777_7ABC, 1'b0, 1'b1, 1'b0, 2'd2}, // R7
    '{32'h0030_1ABC, 32'h0020_0401, 32'h1111_1203, 32'h1111_1ABC, 1'b0, 1'b0, 1'b1, 2'd2}, // R7
    '{32'h0030_1ABC, 32'h0020_0401, 32'hABCD_8001, 32'hABCD_1ABC, 1'b0, 1'b1, 1'b1, 2'd2}, // R8
    '{32'h0030_1ABC, 32'h0020_0401, 32'hABCD_0201, 32'hABCD_1ABC, 1'b0, 1'b0, 1'b0, 2'd2}, // R8
    '{32'h0030_1ABC, 32'h0020_0401, 32'h1234_5FFC, 32'h0,         1'b1, 1'b0, 1'b0, 2'd2}, // R2 L2
    '{32'h0030_1ABC, 32'h0020_07FD, 32'h7777_7002, 32'h7777_7ABC, 1'b0, 1'b1, 1'b0, 2'd2}  // R3
  };

  task automatic load_mem(input vec_t v, input logic [31:0] base);
    logic [31:0] a1, a2;
    mem_q.delete();
    a1 = {base[31:14], v.va[31:20], 2'b00};
    mem_q[a1] = v.l1;
    if (v.l1[0]) begin
      a2 = {v.l1[31:10], v.va[19:12], 2'b00};
      mem_q[a2] = v.l2;
    end
  endtask

  task automatic start_walk(input logic [31:0] va);
    @(negedge clk);
    fetch_cnt = 0;
    req_va    = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int k = 0;
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk(done, req, "done seen", {31'd0, done}, 32'd1);
  endtask

  task automatic check_res(input vec_t v, input string req);
    chk(pa == v.pa, req, "pa", pa, v.pa);
    chk({fault, write_ok, xn} == {v.fault, v.wr, v.xn}, req, "fault/wr/xn",
        {29'd0, fault, write_ok, xn}, {29'd0, v.fault, v.wr, v.xn});
  endtask

  initial begin
    logic [31:0] held;
    int          d0;
    // R12 reset state
    repeat (3) @(negedge clk);
    chk(!done && !mem_req_valid && pa == 0 && !fault && !write_ok && !xn,
        "R12", "reset outputs", {pa[31:4], done, mem_req_valid, fault, xn}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready, "R9", "idle ready", {31'd0, req_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      lat        = i % 4;
      ready_mode = i % 2;
      load_mem(VECS[i], l1_base);
      start_walk(VECS[i].va);
      wait_done($sformatf("R%0d-vec%0d", 1, i));
      check_res(VECS[i], $sformatf("vec%0d R2/R3/R4/R5/R6/R7/R8", i));
      chk(fetch_cnt == int'(VECS[i].nfetch), "R8", "fetch count",
          fetch_cnt, {30'd0, VECS[i].nfetch});
      @(negedge clk);
      chk(!done, "R10", "done one cycle", {31'd0, done}, 32'd0);
    end
    ready_mode = 0;

    // R10 hold after completion
    held = pa;
    repeat (4) @(negedge clk);
    chk(pa == held && !done, "R10", "result held", pa, held);

    // R1 base low bits ignored
    l1_base = 32'h0010_3FFF;
    load_mem(VECS[0], 32'h0010_0000);
    lat = 2;
    start_walk(VECS[0].va);
    wait_done("R1");
    check_res(VECS[0], "R1 base low bits");
    l1_base = 32'h0010_0000;

    // R9 requests while busy ignored
    load_mem(VECS[4], l1_base);
    lat = 6;
    start_walk(VECS[4].va);
    req_va = 32'h1234_5678;
    req_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!req_ready, "R9", "busy not ready", {31'd0, req_ready}, 32'd0);
    end
    req_valid = 1'b0;
    wait_done("R9");
    check_res(VECS[4], "R9 busy request ignored");

    // R11 stray response while idle
    lat = 1;
    repeat (2) @(negedge clk);
    held = pa;
    d0 = done_cnt;
    stray_data = 32'h0000_0000;
    stray_pend = 1'b1;
    repeat (4) @(negedge clk);
    chk(done_cnt == d0 && pa == held && !fault, "R11", "idle stray", pa, held);

    // R11 stray response before memory accepts the fetch
    load_mem(VECS[0], l1_base);
    ready_mode = 2;
    start_walk(VECS[0].va);
    d0 = done_cnt;
    stray_data = 32'h0000_0000;
    stray_pend = 1'b1;
    repeat (4) @(negedge clk);
    chk(done_cnt == d0, "R11", "stray before accept", done_cnt, d0);
    ready_mode = 0;
    wait_done("R11");
    check_res(VECS[0], "R11 walk after stray");

    // R12 reset mid-walk drops fetch
    load_mem(VECS[2], l1_base);
    lat = 8;
    start_walk(VECS[2].va);
    repeat (3) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(pa == 0 && !done && !mem_req_valid, "R12", "reset mid-walk", pa, 32'h0);
    rst_ni = 1'b1;
    d0 = done_cnt;
    repeat (12) @(negedge clk);
    chk(done_cnt == d0 && req_ready && pa == 0, "R12", "late response dropped",
        pa, 32'h0);
    lat = 0;
    load_mem(VECS[6], l1_base);
    start_walk(VECS[6].va);
    wait_done("R12");
    check_res(VECS[6], "R12 walk after reset");

    report();
    $finish;
  end
endmodule